// File: doc/BRIEF.md
# Pulsed Overload and Thermal Protection Controller

This block decides when a regulated output may conduct. It watches a digital overcurrent indication from an analog clamp and a pair of temperature comparators. It drives a regulator enable, an override that forces a pass-through switch open, and two status flags, one for overload and one for overtemperature. A prescaler divides the system clock into a millisecond tick, and that tick paces every protection interval.

The block has two overload policies, chosen by a mode input. In static mode the regulator stays on while the clamp limits the current, and the overload flag tracks the clamp. In pulsed mode an overload switches the output off for a long interval. The output then comes back for a short trial window of one tenth that length. Only a trial window with no overload at all ends the episode. Software may start in static mode, so that a heavily capacitive load can charge, and switch to pulsed mode later while the block runs.

Thermal protection has hysteresis. The trip comparator shuts the regulator off and opens the pass-through switch. Both stay that way until the release comparator reports that the part has cooled below the lower point.

Top module: `guard_ctrl`

## Requirements
- R1: After reset all four outputs are 0. While `en` is 0, `reg_on` and `ovl_flag` read 0 one cycle later, and any pulsed episode is abandoned. Raising `en` with no overload brings `reg_on` to 1 one cycle later.
- R2: In static mode (`pulsed`=0, `en`=1), `reg_on` stays 1 under overload, and `ovl_flag` equals `ovl_det` delayed by one cycle.
- R3: In pulsed mode with no episode running, `ovl_det`=1 gives `reg_on`=0 and `ovl_flag`=1 one cycle later.
- R4: The off interval lasts exactly OFF_TICKS×CLK_DIV cycles. The prescaler restarts when each phase begins. After that interval `reg_on` returns to 1 for a trial window of exactly ON_TICKS×CLK_DIV cycles.
- R5: If `ovl_det` is 1 in any cycle of the trial window, a new off interval starts when the window ends, and `ovl_flag` stays 1.
- R6: When a whole trial window passes with no overload, `ovl_flag` drops to 0 at the window's end and `reg_on` stays 1.
- R7: Changing `pulsed` from 0 to 1 while `ovl_det` is 1 starts an off interval one cycle later. Changing it from 1 to 0 during an episode ends the episode one cycle later: `reg_on` goes to 1 and `ovl_flag` follows `ovl_det`.
- R8: `hot_trip`=1 gives `hot_flag`=1, `lt_open`=1 and `reg_on`=0 one cycle later, whatever the value of `en`.
- R9: The thermal state clears only in a cycle where `cool_ok`=1 and `hot_trip`=0, and it takes effect one cycle later. If both comparators are 1, the trip wins. With both at 0 the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Regulator enable request |
| pulsed | input | 1 | Overload policy: 1 = pulsed off/retry, 0 = static clamp |
| ovl_det | input | 1 | Overcurrent clamp active |
| hot_trip | input | 1 | Temperature above the upper trip point |
| cool_ok | input | 1 | Temperature below the lower release point |
| reg_on | output | 1 | Regulator output enable |
| lt_open | output | 1 | Forces the pass-through switch open |
| ovl_flag | output | 1 | Overload status |
| hot_flag | output | 1 | Overtemperature status |

## Verification
Each output is registered, so a change on `en`, `pulsed`, `ovl_det` or a comparator shows up exactly one cycle after the edge that samples it. In pulsed mode, the edge that ends the off interval comes OFF_TICKS×CLK_DIV cycles after the edge that entered it. The edge that ends the trial window comes ON_TICKS×CLK_DIV cycles after that. Every expectation carries the absolute cycle in which it is due, computed from these counts. The monitor compares it a few nanoseconds after that cycle's edge. The checks are placed on both sides of each boundary, at the last cycle of off and the first of on, and at the last cycle of the window and the next, so a one-cycle slip is caught.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OFF   = 2'd1,
        PH_RETRY = 2'd2
    } phase_t;

endpackage

// File: rtl/guard_tick.sv
module guard_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (clr || cnt_q == LAST) cnt_d = '0;
                else                      cnt_d = cnt_q + W'(1);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/guard_thermal.sv
module guard_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic cool,
    output logic hot_d,
    output logic hot_q
);
    always_comb begin
        if (trip)      hot_d = 1'b1;
        else if (cool) hot_d = 1'b0;
        else           hot_d = hot_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hot_q <= 1'b0;
        else        hot_q <= hot_d;
    end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
    import guard_pkg::*;
#(
    parameter int CLK_DIV   = 50000,
    parameter int OFF_TICKS = 900,
    parameter int ON_TICKS  = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pulsed,
    input  logic ovl_det,
    input  logic hot_trip,
    input  logic cool_ok,
    output logic reg_on,
    output logic lt_open,
    output logic ovl_flag,
    output logic hot_flag
);
    localparam int MAXT = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
    localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

    typedef struct packed {
        phase_t        phase;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          reg_on;
        logic          ovl;
    } ctl_t;

    ctl_t r_q, r_d;
    logic tick, clr, hot_d, hot_q;

    guard_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .tick (tick)
    );

    guard_thermal u_therm (
        .clk  (clk),
        .rst_n(rst_n),
        .trip (hot_trip),
        .cool (cool_ok),
        .hot_d(hot_d),
        .hot_q(hot_q)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (en && pulsed && ovl_det) begin
                    r_d.phase = PH_OFF;
                    r_d.cnt   = '0;
                end
            end
            PH_OFF: begin
                if (tick) begin
                    if (r_q.cnt == OFF_LAST) begin
                        r_d.phase = PH_RETRY;
                        r_d.cnt   = '0;
                        r_d.seen  = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
            end
            PH_RETRY: begin
                r_d.seen = r_q.seen | ovl_det;
                if (tick) begin
                    if (r_q.cnt == ON_LAST) begin
                        r_d.phase = (r_q.seen || ovl_det) ? PH_OFF : PH_IDLE;
                        r_d.cnt   = '0;
                        r_d.seen  = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
            end
            default: begin
                r_d.phase = PH_IDLE;
                r_d.cnt   = '0;
            end
        endcase

        if (!en || !pulsed) begin
            r_d.phase = PH_IDLE;
            r_d.cnt   = '0;
            r_d.seen  = 1'b0;
        end

        r_d.reg_on = en && !hot_d && (r_d.phase != PH_OFF);
        r_d.ovl    = en && (pulsed ? (r_d.phase != PH_IDLE) : ovl_det);
    end

    assign clr = (r_d.phase != r_q.phase);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase  <= PH_IDLE;
            r_q.cnt    <= '0;
            r_q.seen   <= 1'b0;
            r_q.reg_on <= 1'b0;
            r_q.ovl    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_on   = r_q.reg_on;
    assign ovl_flag = r_q.ovl;
    assign hot_flag = hot_q;
    assign lt_open  = hot_q;
endmodule

// File: rtl/guard_ctrl_chk.sv
module guard_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic pulsed,
    input logic ovl_det,
    input logic hot_trip,
    input logic cool_ok,
    input logic reg_on,
    input logic lt_open,
    input logic ovl_flag,
    input logic hot_flag
);
    AST_EN_LOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!reg_on && !ovl_flag)); // R1

    AST_STATIC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pulsed) |=> ((ovl_flag == $past(ovl_det)) && (reg_on || hot_flag))); // R2

    AST_PULSE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pulsed && ovl_det && !ovl_flag) |=> (ovl_flag && !reg_on)); // R3

    AST_HOT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        hot_trip |=> (hot_flag && lt_open && !reg_on)); // R8

    AST_HOT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |-> !reg_on); // R8

    AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_flag && !cool_ok) |=> hot_flag); // R9
endmodule

bind guard_ctrl guard_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pulsed  (pulsed),
    .ovl_det (ovl_det),
    .hot_trip(hot_trip),
    .cool_ok (cool_ok),
    .reg_on  (reg_on),
    .lt_open (lt_open),
    .ovl_flag(ovl_flag),
    .hot_flag(hot_flag)
);

// File: tb/sim_guard_ctrl.sv
`timescale 1ns/1ps
module sim_guard_ctrl;
    localparam int DIV  = 4;
    localparam int OFFT = 10;
    localparam int ONT  = 3;
    localparam int OFFC = OFFT * DIV;
    localparam int ONC  = ONT * DIV;

    logic clk = 1'b0;
    logic rst_n, en, pulsed, ovl_det, hot_trip, cool_ok;
    logic reg_on, lt_open, ovl_flag, hot_flag;

    always #10 clk = ~clk;

    guard_ctrl #(.CLK_DIV(DIV), .OFF_TICKS(OFFT), .ON_TICKS(ONT)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pulsed(pulsed), .ovl_det(ovl_det),
        .hot_trip(hot_trip), .cool_ok(cool_ok), .reg_on(reg_on), .lt_open(lt_open),
        .ovl_flag(ovl_flag), .hot_flag(hot_flag)
    );

    typedef struct {
        int         due;
        logic [3:0] mask;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    // expected bits: {reg_on, lt_open, ovl_flag, hot_flag}
    task automatic push(input int due, input logic [3:0] mask, input logic [3:0] val, input string tag);
        exp_t e;
        int   pos;
        e.due = due; e.mask = mask; e.val = val; e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > due) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                logic [3:0] act;
                e = q.pop_front();
                act = {reg_on, lt_open, ovl_flag, hot_flag};
                n_chk++;
                if ((act & e.mask) !== (e.val & e.mask)) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             e.tag, cyc, act, e.val, e.mask);
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        int b;
        rst_n = 1'b0; en = 1'b0; pulsed = 1'b0; ovl_det = 1'b0;
        hot_trip = 1'b0; cool_ok = 1'b0;
        step(3);
        rst_n = 1'b1;
        push(cyc + 1, 4'b1111, 4'b0000, "R1 reset state");
        step(2);

        // R2 static clamp
        en = 1'b1;
        push(cyc + 1, 4'b1010, 4'b1000, "R1 enable on");
        step(1);
        ovl_det = 1'b1;
        push(cyc + 1, 4'b1010, 4'b1010, "R2 static overload stays on");
        step(3);
        ovl_det = 1'b0;
        push(cyc + 1, 4'b1010, 4'b1000, "R2 static flag clears");
        step(2);
        ovl_det = 1'b1; en = 1'b0;
        push(cyc + 1, 4'b1111, 4'b0000, "R1 enable low");
        step(2);
        ovl_det = 1'b0; en = 1'b1;
        step(2);

        // R3/R4/R6 clean pulsed episode
        pulsed = 1'b1;
        step(2);
        b = cyc;
        ovl_det = 1'b1;
        push(b + 1,        4'b1010, 4'b0010, "R3 pulsed trip");
        push(b + OFFC,     4'b1010, 4'b0010, "R4 last off cycle");
        push(b + OFFC + 1, 4'b1010, 4'b1010, "R4 retry on");
        push(b + OFFC + ONC,     4'b1010, 4'b1010, "R6 last retry cycle");
        push(b + OFFC + ONC + 1, 4'b1010, 4'b1000, "R6 clean recovery");
        step(1);
        ovl_det = 1'b0;
        step(OFFC + ONC + 6);

        // R5 overload inside retry window
        b = cyc;
        ovl_det = 1'b1;
        push(b + 1,                    4'b1010, 4'b0010, "R3 second trip");
        push(b + OFFC + ONC,           4'b1010, 4'b1010, "R5 window end on");
        push(b + OFFC + ONC + 1,       4'b1010, 4'b0010, "R5 cycles again");
        push(b + 2*OFFC + ONC,         4'b1010, 4'b0010, "R5 second off last");
        push(b + 2*OFFC + ONC + 1,     4'b1010, 4'b1010, "R5 second retry");
        push(b + 2*OFFC + 2*ONC + 1,   4'b1010, 4'b1000, "R6 recovery after repeat");
        step(1);
        ovl_det = 1'b0;
        step(OFFC + 4);
        ovl_det = 1'b1;
        step(1);
        ovl_det = 1'b0;
        step(OFFC + 2*ONC);

        // R1 enable low aborts episode
        b = cyc;
        ovl_det = 1'b1;
        push(b + 1, 4'b1010, 4'b0010, "R3 trip before abort");
        step(1);
        ovl_det = 1'b0;
        step(9);
        en = 1'b0;
        push(cyc + 1, 4'b1010, 4'b0000, "R1 abort clears flag");
        step(1);
        en = 1'b1;
        push(cyc + 1, 4'b1010, 4'b1000, "R1 re-enable idle");
        step(4);

        // R7 pulsed -> static mid episode
        ovl_det = 1'b1;
        push(cyc + 1, 4'b1010, 4'b0010, "R3 trip before mode change");
        step(1);
        ovl_det = 1'b0;
        step(4);
        pulsed = 1'b0;
        push(cyc + 1, 4'b1010, 4'b1000, "R7 switch to static");
        step(2);

        // R7 static -> pulsed with overload present
        ovl_det = 1'b1;
        push(cyc + 1, 4'b1010, 4'b1010, "R7 static clamp");
        step(3);
        pulsed = 1'b1;
        push(cyc + 1, 4'b1010, 4'b0010, "R7 switch to pulsed");
        step(1);
        ovl_det = 1'b0;
        step(1);
        en = 1'b0;
        step(2);
        en = 1'b1; pulsed = 1'b0;
        step(2);

        // R8/R9 thermal
        hot_trip = 1'b1;
        push(cyc + 1, 4'b1111, 4'b0101, "R8 trip");
        step(1);
        hot_trip = 1'b0;
        push(cyc + 4, 4'b1111, 4'b0101, "R9 hold between points");
        step(4);
        en = 1'b0;
        push(cyc + 1, 4'b1101, 4'b0101, "R8 open with enable low");
        step(2);
        cool_ok = 1'b1;
        push(cyc + 1, 4'b1111, 4'b0000, "R9 release");
        step(1);
        cool_ok = 1'b0; en = 1'b1;
        push(cyc + 1, 4'b1111, 4'b1000, "R9 output restored");
        step(2);
        hot_trip = 1'b1; cool_ok = 1'b1;
        push(cyc + 1, 4'b1101, 4'b0101, "R9 trip wins");
        step(1);
        hot_trip = 1'b0;
        push(cyc + 1, 4'b1101, 4'b1000, "R9 clear after trip drops");
        step(3);

        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule